// File: doc/BRIEF.md
# JTAG Boundary-Scan Test Port with Core Reset

This block is a test access port in the style of IEEE 1149.1. It is clocked only by TCK. It contains the sixteen-state TAP controller, a 4-bit instruction register with its decoder, and four data registers behind one multiplexer:

- a single-bit bypass stage,
- a 32-bit identification register,
- a one-bit core-reset register,
- an eight-cell boundary chain whose update latches can take over the pin values.

A board tester uses the port in four ways:

- It reads the identification code straight out of reset.
- It shortens the chain with bypass.
- It snapshots and preloads pin values safely before driving them.
- It can hold the processor core in reset through a private instruction.

The whole port is switched on by a programmed enable fuse together with a disable bit that software clears. While it is switched off, the controller is pinned in Test-Logic-Reset and TDO is never enabled.

The block has no functional clock input, so scan keeps working when the system clock is stopped or slower than TCK. The shift stages and the controller act on the rising edge of TCK. The instruction latch, the update latches and the TDO driver act on the falling edge.

Top module: `jtag_tap_top`

## Requirements
- R1: Test-Logic-Reset sets the instruction to IDCODE (0x1). It is entered by `trst` held high at a TCK rising edge, or by five TCK rising edges with TMS high. Entering it also clears the core-reset bit and all boundary update latches. A data scan with no instruction scan first then returns the 32-bit identification value, whose bit 0 is always 1.
- R2: The instruction register is 4 bits wide and shifts LSB first from TDI toward TDO. An instruction scan shifts out the captured pattern 0b0001.
- R3: Instruction codes are 0x0 drive-pins (EXTEST), 0x1 identify, 0x2 sample/preload, 0xC core reset and 0xF bypass. Every other code behaves exactly like bypass.
- R4: The bypass path is one stage that loads 0 on capture. The first bit out of a data scan is 0, and each later output bit is the TDI bit shifted in one clock earlier.
- R5: Sample/preload works as follows. Capture loads `pins_in` into the chain, with cell i taking pin i and cell 0 leaving first. Update-DR copies the chain into the update latches. `bnd_sel` stays 0 throughout.
- R6: The drive-pins instruction works as follows. `bnd_sel` goes high at the falling edge in Update-IR, and `bnd_val` at once shows the latches loaded earlier, with no data scan. A data scan under this instruction captures `pins_in` and updates `bnd_val`.
- R7: The core-reset data register is one bit. Capture loads its present value, and Update-DR changes it. `core_rst` is high while that bit is 1 or while `pin_rst_n` is low.
- R8: TDO changes on the falling edge of TCK. `tdo_oe` is high only in Shift-IR and Shift-DR.
- R9: The port runs only when `fuse_en` is 1 and `jtag_dis` is 0. Otherwise `tdo_oe` stays 0 and the controller is held in Test-Logic-Reset, so a later data scan returns the identification value.
- R10: `bnd_val` changes only at a falling edge in Update-DR or in Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| fuse_en | input | 1 | Enable fuse, 1 when programmed |
| jtag_dis | input | 1 | Software disable bit, port off when 1 |
| pin_rst_n | input | 1 | External core reset pin, active low |
| pins_in | input | BSR_LEN | Live pin values seen by the boundary chain |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for TDO |
| bnd_val | output | BSR_LEN | Values held in the boundary update latches |
| bnd_sel | output | 1 | 1 when the latches drive the pins |
| core_rst | output | 1 | Reset request to the processor core |

## Verification
The bench targets four corner cases:

- **Immediate pin drive.** It preloads safe values under sample/preload and then loads the drive-pins instruction. A design that waited for a data scan would show the wrong `bnd_val`. A design that let sample/preload drive the pins would raise `bnd_sel` too early.
- **Core reset.** It sets and clears the reset bit and checks the captured value each time. It also pulls the external pin low with the bit clear, which a design without the OR would miss.
- **TMS-only reset.** It checks that this path restores IDCODE and clears the latches.
- **Disabled port.** It scans while the fuse is off and again while the disable bit is set. A leaky enable would show TDO driven, and a port not held in reset would not return the identification code afterwards.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_EXTEST = 4'h0;
    localparam logic [IR_W-1:0] OP_IDCODE = 4'h1;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'h2;
    localparam logic [IR_W-1:0] OP_CRST   = 4'hC;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;

    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [1:0] {
        SEL_BYP, SEL_ID, SEL_BSR, SEL_CRST
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e sel;
        logic    drive;
    } instr_dec_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        unique case (s)
            ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic instr_dec_t decode_op(input logic [IR_W-1:0] op);
        instr_dec_t d;
        d.drive = 1'b0;
        unique case (op)
            OP_EXTEST: begin d.sel = SEL_BSR; d.drive = 1'b1; end
            OP_IDCODE: d.sel = SEL_ID;
            OP_SAMPLE: d.sel = SEL_BSR;
            OP_CRST:   d.sel = SEL_CRST;
            default:   d.sel = SEL_BYP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) begin
            state <= ST_RESET;
        end else begin
            state <= tap_next(state, tms);
        end
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_q,
    output logic            so,
    output instr_dec_t      dec
);

    logic [IR_W-1:0] sh_q;

    always_ff @(posedge tck) begin
        if (state == ST_CAP_IR) begin
            sh_q <= IR_CAPTURE;
        end else if (state == ST_SHF_IR) begin
            sh_q <= {tdi, sh_q[IR_W-1:1]};
        end
    end

    always_ff @(negedge tck) begin
        if (state == ST_RESET) begin
            ir_q <= OP_IDCODE;
        end else if (state == ST_UPD_IR) begin
            ir_q <= sh_q;
        end
    end

    assign so  = sh_q[0];
    assign dec = decode_op(ir_q);

endmodule

// File: rtl/tap_aux_regs.sv
module tap_aux_regs
    import jtag_tap_pkg::*;
#(
    parameter int          ID_W   = 32,
    parameter logic [31:0] ID_VAL = 32'h4A7E_1035
) (
    input  logic       tck,
    input  logic       tdi,
    input  tap_state_e state,
    input  dr_sel_e    sel,
    output logic       byp_so,
    output logic       id_so,
    output logic       crst_so,
    output logic       crst_q
);

    localparam logic [ID_W-1:0] ID_CAP = ID_VAL[ID_W-1:0] | {{(ID_W-1){1'b0}}, 1'b1};

    logic            byp_q;
    logic [ID_W-1:0] id_q;
    logic            crst_sh;

    always_ff @(posedge tck) begin
        if (state == ST_CAP_DR) begin
            unique case (sel)
                SEL_BYP:  byp_q   <= 1'b0;
                SEL_ID:   id_q    <= ID_CAP;
                SEL_CRST: crst_sh <= crst_q;
                default:  ;
            endcase
        end else if (state == ST_SHF_DR) begin
            unique case (sel)
                SEL_BYP:  byp_q   <= tdi;
                SEL_ID:   id_q    <= {tdi, id_q[ID_W-1:1]};
                SEL_CRST: crst_sh <= tdi;
                default:  ;
            endcase
        end
    end

    always_ff @(negedge tck) begin
        if (state == ST_RESET) begin
            crst_q <= 1'b0;
        end else if (state == ST_UPD_DR && sel == SEL_CRST) begin
            crst_q <= crst_sh;
        end
    end

    assign byp_so  = byp_q;
    assign id_so   = id_q[0];
    assign crst_so = crst_sh;

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
    import jtag_tap_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         tck,
    input  logic         tdi,
    input  tap_state_e   state,
    input  logic         sel,
    input  logic [N-1:0] pins_in,
    output logic         so,
    output logic [N-1:0] upd_q
);

    logic [N-1:0] cap_q;

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic nxt;
        logic cap_c;
        logic upd_c;

        if (i == N-1) begin : g_head
            assign nxt = tdi;
        end else begin : g_link
            assign nxt = cap_q[i+1];
        end

        always_ff @(posedge tck) begin
            if (sel && state == ST_CAP_DR) begin
                cap_c <= pins_in[i];
            end else if (sel && state == ST_SHF_DR) begin
                cap_c <= nxt;
            end
        end

        always_ff @(negedge tck) begin
            if (state == ST_RESET) begin
                upd_c <= 1'b0;
            end else if (sel && state == ST_UPD_DR) begin
                upd_c <= cap_c;
            end
        end

        assign cap_q[i] = cap_c;
        assign upd_q[i] = upd_c;
    end

    assign so = cap_q[0];

endmodule

// File: rtl/jtag_tap_top.sv
module jtag_tap_top
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN = 8,
    parameter int          ID_W    = 32,
    parameter logic [31:0] ID_VAL  = 32'h4A7E_1035
) (
    input  logic               tck,
    input  logic               trst,
    input  logic               tms,
    input  logic               tdi,
    input  logic               fuse_en,
    input  logic               jtag_dis,
    input  logic               pin_rst_n,
    input  logic [BSR_LEN-1:0] pins_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [BSR_LEN-1:0] bnd_val,
    output logic               bnd_sel,
    output logic               core_rst
);

    tap_state_e      state;
    logic [IR_W-1:0] ir;
    instr_dec_t      dec;
    logic            port_on;
    logic            rst_eff;
    logic            ir_so;
    logic            bsr_so;
    logic            byp_so;
    logic            id_so;
    logic            crst_so;
    logic            crst_q;
    logic            dr_so;
    logic            tdo_q;
    logic            oe_q;

    assign port_on = fuse_en & ~jtag_dis;
    assign rst_eff = trst | ~port_on;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst_eff),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck   (tck),
        .tdi   (tdi),
        .state (state),
        .ir_q  (ir),
        .so    (ir_so),
        .dec   (dec)
    );

    tap_aux_regs #(
        .ID_W   (ID_W),
        .ID_VAL (ID_VAL)
    ) u_aux (
        .tck     (tck),
        .tdi     (tdi),
        .state   (state),
        .sel     (dec.sel),
        .byp_so  (byp_so),
        .id_so   (id_so),
        .crst_so (crst_so),
        .crst_q  (crst_q)
    );

    tap_bsr #(
        .N (BSR_LEN)
    ) u_bsr (
        .tck     (tck),
        .tdi     (tdi),
        .state   (state),
        .sel     (dec.sel == SEL_BSR),
        .pins_in (pins_in),
        .so      (bsr_so),
        .upd_q   (bnd_val)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_ID:   dr_so = id_so;
            SEL_BSR:  dr_so = bsr_so;
            SEL_CRST: dr_so = crst_so;
            default:  dr_so = byp_so;
        endcase
    end

    always_ff @(negedge tck) begin
        if (state == ST_SHF_IR) begin
            tdo_q <= ir_so;
            oe_q  <= 1'b1;
        end else if (state == ST_SHF_DR) begin
            tdo_q <= dr_so;
            oe_q  <= 1'b1;
        end else begin
            oe_q  <= 1'b0;
        end
    end

    assign tdo      = tdo_q;
    assign tdo_oe   = oe_q;
    assign bnd_sel  = dec.drive;
    assign core_rst = crst_q | ~pin_rst_n;

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
    import jtag_tap_pkg::*;
#(
    parameter int N = 8
) (
    input logic            tck,
    input logic            trst,
    input logic            fuse_en,
    input logic            jtag_dis,
    input logic            pin_rst_n,
    input logic            tdo_oe,
    input logic [N-1:0]    bnd_val,
    input logic            bnd_sel,
    input logic            core_rst,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir
);

    // R1
    tlr_idcode_chk: assert property (@(posedge tck) disable iff (trst)
        state == ST_RESET |-> ir == OP_IDCODE);

    // R6
    drive_drop_chk: assert property (@(posedge tck) disable iff (trst)
        $fell(bnd_sel) |-> (state == ST_UPD_IR || state == ST_RESET));

    // R7
    crst_rise_chk: assert property (@(posedge tck) disable iff (trst)
        $rose(core_rst) && pin_rst_n |-> state == ST_UPD_DR);

    // R8
    oe_shift_chk: assert property (@(posedge tck) disable iff (trst)
        tdo_oe |-> (state == ST_SHF_DR || state == ST_SHF_IR));

    // R9
    port_off_chk: assert property (@(posedge tck) disable iff (trst)
        (!fuse_en || jtag_dis) && $past(!fuse_en || jtag_dis) |-> !tdo_oe);

    // R10
    latch_hold_chk: assert property (@(posedge tck) disable iff (trst)
        !(state == ST_UPD_DR || state == ST_RESET) |-> $stable(bnd_val));

endmodule

bind jtag_tap_top jtag_tap_chk #(.N(BSR_LEN)) u_chk (
    .tck       (tck),
    .trst      (trst),
    .fuse_en   (fuse_en),
    .jtag_dis  (jtag_dis),
    .pin_rst_n (pin_rst_n),
    .tdo_oe    (tdo_oe),
    .bnd_val   (bnd_val),
    .bnd_sel   (bnd_sel),
    .core_rst  (core_rst),
    .state     (state),
    .ir        (ir)
);

// File: tb/jtag_tap_top_test.sv
`timescale 1ns/1ps
module jtag_tap_top_test;

    localparam logic [31:0] ID_EXP = 32'h4A7E_1035;

    typedef struct packed {
        logic [3:0]  op;
        logic [5:0]  len;
        logic [31:0] din;
        logic [31:0] exp;
    } vec_t;

    // R1 identify, R4 bypass, R3 unused codes as bypass, R5 sample capture, R7 capture of clear bit
    localparam vec_t VECS [6] = '{
        '{4'h1, 6'd32, 32'h0000_0000, ID_EXP},
        '{4'hF, 6'd4,  32'h0000_000B, 32'h0000_0006},
        '{4'h7, 6'd4,  32'h0000_000B, 32'h0000_0006},
        '{4'h9, 6'd4,  32'h0000_0005, 32'h0000_000A},
        '{4'h2, 6'd8,  32'h0000_0000, 32'h0000_00A5},
        '{4'hC, 6'd1,  32'h0000_0000, 32'h0000_0000}
    };

    logic       tck = 1'b0;
    logic       trst = 1'b1;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       fuse_en = 1'b1;
    logic       jtag_dis = 1'b0;
    logic       pin_rst_n = 1'b1;
    logic [7:0] pins_in = 8'hA5;
    logic       tdo;
    logic       tdo_oe;
    logic [7:0] bnd_val;
    logic       bnd_sel;
    logic       core_rst;

    int  total = 0;
    int  bad = 0;
    logic any_oe = 1'b0;
    logic done = 1'b0;

    always #5 tck = ~tck;

    jtag_tap_top uut (
        .tck       (tck),
        .trst      (trst),
        .tms       (tms),
        .tdi       (tdi),
        .fuse_en   (fuse_en),
        .jtag_dis  (jtag_dis),
        .pin_rst_n (pin_rst_n),
        .pins_in   (pins_in),
        .tdo       (tdo),
        .tdo_oe    (tdo_oe),
        .bnd_val   (bnd_val),
        .bnd_sel   (bnd_sel),
        .core_rst  (core_rst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        o = tdo;
        e = tdo_oe;
        any_oe = any_oe | tdo_oe;
        @(posedge tck);
        #1;
    endtask

    task automatic scan_dr(input int len, input logic [31:0] din,
                           output logic [31:0] dout, output logic oe_all);
        logic o;
        logic e;
        dout = '0;
        oe_all = 1'b1;
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        for (int i = 0; i < len; i++) begin
            step(i == len - 1, din[i], o, e);
            dout[i] = o;
            oe_all = oe_all & e;
        end
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
        logic o;
        logic e;
        cap = '0;
        step(1'b1, 1'b0, o, e);
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, op[i], o, e);
            cap[i] = o;
        end
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic tms_reset();
        logic o;
        logic e;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] dout;
        logic [3:0]  cap;
        logic        oe_all;
        logic        o;
        logic        e;

        repeat (3) @(posedge tck);
        #1;
        // R1 / R8: reset state
        chk("R8 reset tdo_oe", 32'(tdo_oe), 32'h0);
        chk("R1 reset bnd_sel", 32'(bnd_sel), 32'h0);
        chk("R1 reset core_rst", 32'(core_rst), 32'h0);
        chk("R1 reset bnd_val", 32'(bnd_val), 32'h0);
        trst = 1'b0;
        step(1'b0, 1'b0, o, e);
        scan_dr(32, 32'h0, dout, oe_all);
        chk("R1 id after reset", dout, ID_EXP);

        // R2 R3 table walk
        foreach (VECS[k]) begin
            scan_ir(VECS[k].op, cap);
            chk($sformatf("R2 ir capture vec%0d", k), 32'(cap), 32'h1);
            scan_dr(int'(VECS[k].len), VECS[k].din, dout, oe_all);
            chk($sformatf("R3 dr out vec%0d", k), dout, VECS[k].exp);
            chk($sformatf("R8 oe in shift vec%0d", k), 32'(oe_all), 32'h1);
            chk($sformatf("R8 oe idle vec%0d", k), 32'(tdo_oe), 32'h0);
        end

        // R5: preload under sample does not drive
        scan_ir(4'h2, cap);
        scan_dr(8, 32'h3C, dout, oe_all);
        chk("R5 sample capture", dout, 32'hA5);
        chk("R5 sample no drive", 32'(bnd_sel), 32'h0);

        // R6: drive-pins takes effect at Update-IR
        scan_ir(4'h0, cap);
        chk("R6 drive select", 32'(bnd_sel), 32'h1);
        chk("R6 preload shown", 32'(bnd_val), 32'h3C);
        pins_in = 8'h69;
        scan_dr(8, 32'h5A, dout, oe_all);
        chk("R6 extest capture", dout, 32'h69);
        chk("R6 extest update", 32'(bnd_val), 32'h5A);

        // R7: core reset register
        scan_ir(4'hC, cap);
        chk("R6 drive released", 32'(bnd_sel), 32'h0);
        chk("R10 latch held", 32'(bnd_val), 32'h5A);
        scan_dr(1, 32'h1, dout, oe_all);
        chk("R7 capture clear", dout, 32'h0);
        chk("R7 reset set", 32'(core_rst), 32'h1);
        scan_dr(1, 32'h0, dout, oe_all);
        chk("R7 capture set", dout, 32'h1);
        chk("R7 reset cleared", 32'(core_rst), 32'h0);
        pin_rst_n = 1'b0;
        #1;
        chk("R7 pin reset", 32'(core_rst), 32'h1);
        pin_rst_n = 1'b1;
        #1;
        chk("R7 pin released", 32'(core_rst), 32'h0);

        // R1: TMS-only reset clears everything
        scan_dr(1, 32'h1, dout, oe_all);
        tms_reset();
        chk("R1 tms reset core", 32'(core_rst), 32'h0);
        chk("R1 tms reset latches", 32'(bnd_val), 32'h0);
        scan_dr(32, 32'h0, dout, oe_all);
        chk("R1 tms reset id", dout, ID_EXP);

        // R9: fuse off
        scan_ir(4'hF, cap);
        fuse_en = 1'b0;
        any_oe = 1'b0;
        scan_ir(4'h2, cap);
        scan_dr(4, 32'hF, dout, oe_all);
        chk("R9 fuse off oe", 32'(any_oe), 32'h0);
        fuse_en = 1'b1;
        step(1'b0, 1'b0, o, e);
        scan_dr(32, 32'h0, dout, oe_all);
        chk("R9 fuse reenable id", dout, ID_EXP);

        // R9: disable bit set
        scan_ir(4'hF, cap);
        jtag_dis = 1'b1;
        any_oe = 1'b0;
        scan_dr(4, 32'hF, dout, oe_all);
        chk("R9 disable oe", 32'(any_oe), 32'h0);
        jtag_dis = 1'b0;
        step(1'b0, 1'b0, o, e);
        scan_dr(32, 32'h0, dout, oe_all);
        chk("R9 disable cleared id", dout, ID_EXP);

        done = 1'b1;
        finish_run();
    end

endmodule